// File: doc/BRIEF.md
# LCD common-line scan shifter

This block drives the row (common) electrodes of a passive-matrix LCD. It holds a chain of 120 scan stages. A scan bit enters the chain from a serial input and advances one stage on every falling edge of the line pulse. A run-time direction input selects the end where the bit enters and the way it travels. The bit that reaches the far end of the chain appears on a serial output, so several devices can be cascaded.

Each stage drives a 2-bit level code that selects one of four drive voltages. A frame AC input picks the polarity, and that polarity sets which voltages mean "selected" and "not selected". An active-low display-off input forces every output to ground and empties the chain. After display-off is released, the outputs sit at the non-select level until the next line-pulse fall shifts in new data.

The line pulse, direction, display-off, frame and data inputs are sampled with the block clock, which must run well above the line rate. Reset is asynchronous and active low.

Top module: `com_scan_shifter`

## Requirements
- R1: While reset is low, and after it is released, every stage is empty and every output shows the non-select code for the current frame value (2'b11 when frame is 0, 2'b10 when frame is 1).
- R2: The chain moves only on a falling edge of the line pulse. Such an edge is seen on the first clock edge at which the line pulse is low after having been high, and the chain moves exactly one stage per falling edge. A rising edge, or a line pulse held at one level, leaves the chain unchanged.
- R3: When the direction input is 1, the data input enters stage 0 and every stage k takes the old value of stage k-1, so a bit travels from stage 0 toward stage 119.
- R4: When the direction input is 0, the data input enters stage 119 and every stage k takes the old value of stage k+1, so a bit travels from stage 119 toward stage 0.
- R5: The data output shows the contents of the far-end stage for the current direction: stage 119 when direction is 1, stage 0 when direction is 0.
- R6: While display-off is low, every output shows the ground code 2'b00, whatever the chain holds and whatever the frame value.
- R7: While display-off is low, the chain is cleared on each clock edge and line-pulse falls are ignored. After release, every output shows the non-select code until a later line-pulse fall shifts data in.
- R8: Output k uses bits [2k+1:2k]. With frame 0, a stage holding 1 drives 2'b01 (V0) and an empty stage drives 2'b11 (V4). With frame 1, a stage holding 1 drives 2'b00 (VSS) and an empty stage drives 2'b10 (V1). The output follows a change of frame at once, with no change to the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all inputs |
| rst_n | input | 1 | Asynchronous reset, active low |
| lp | input | 1 | Line pulse; the chain shifts on its falling edge |
| dir | input | 1 | Shift direction: 1 moves data toward stage 119, 0 toward stage 0 |
| disp_off_n | input | 1 | Display-off, active low: blanks the outputs and clears the chain |
| frame | input | 1 | Frame AC polarity select |
| din | input | 1 | Serial scan data into the entry stage |
| dout | output | 1 | Serial scan data from the far-end stage, for cascading |
| com_lvl | output | 240 | Level codes, two bits per common line; line k uses bits [2k+1:2k] |

## Verification
A wrong stage value appears on its own 2-bit output as soon as the clock edge that loaded it has passed. A stage that is lost or duplicated during a shift shows up at the next line-pulse fall as a code in the wrong position. A chain that moves on the wrong edge, or moves twice, shifts the whole output pattern by one place within one clock of that edge. A wrong state at the far end shows up on the data output only once the bit has travelled there, up to 119 falls later, so the bench walks a single bit through the whole length in each direction. A chain that is not cleared by display-off is hidden while the outputs are blanked, and shows up as a selected line on the first cycle after release.

// File: rtl/com_scan_pkg.sv
package com_scan_pkg;

  // Drive level codes: each common output selects one of four voltages
  typedef enum logic [1:0] {
    LVL_GND = 2'b00,
    LVL_V0  = 2'b01,
    LVL_V1  = 2'b10,
    LVL_V4  = 2'b11
  } drive_lvl_e;

  // Polarity-dependent level for one line.
  // enable low blanks to ground; frame picks the select/non-select pair.
  function automatic drive_lvl_e lvl_of(input logic sel, input logic frame,
                                        input logic enable);
    drive_lvl_e r;
    if (!enable)      r = LVL_GND;
    else if (!frame)  r = sel ? LVL_V0  : LVL_V4;
    else              r = sel ? LVL_GND : LVL_V1;
    return r;
  endfunction

  // Index of the stage a bit enters for a given direction
  function automatic int unsigned entry_index(input logic dir, input int unsigned n);
    return dir ? 0 : n - 1;
  endfunction

  // Index of the stage a bit leaves from for a given direction
  function automatic int unsigned exit_index(input logic dir, input int unsigned n);
    return dir ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/com_lp_edge.sv
module com_lp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lp,
  output logic fall
);

  logic lp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= lp;
  end

  assign fall = lp_q & ~lp;

  // R2: one detected fall per edge of the line pulse, never two in a row
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/com_scan_chain.sv
module com_scan_chain #(
  parameter int unsigned NUM_STAGES = 120
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  shift,
  input  logic                  clear,
  input  logic                  dir,
  input  logic                  din,
  output logic [NUM_STAGES-1:0] stage_q,
  output logic                  dout
);

  localparam int unsigned LAST = NUM_STAGES - 1;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    logic from_low;   // value arriving when moving toward higher indices
    logic from_high;  // value arriving when moving toward lower indices
    logic nxt;

    if (i == 0) begin : g_first
      assign from_low = din;
    end else begin : g_mid_lo
      assign from_low = stage_q[i-1];
    end

    if (i == LAST) begin : g_last
      assign from_high = din;
    end else begin : g_mid_hi
      assign from_high = stage_q[i+1];
    end

    assign nxt = dir ? from_low : from_high;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage_q[i] <= 1'b0;
      else if (clear)  stage_q[i] <= 1'b0;
      else if (shift)  stage_q[i] <= nxt;
    end
  end

  assign dout = dir ? stage_q[LAST] : stage_q[0];

  // R2: without a shift or clear the chain holds
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clear) |=> $stable(stage_q));

  // R3: upward move takes din at stage 0 and the old neighbour at the top
  p_shift_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clear && dir) |=>
      (stage_q[0] == $past(din)) && (stage_q[LAST] == $past(stage_q[LAST-1])));

  // R4: downward move takes din at the top stage and the old neighbour at 0
  p_shift_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clear && !dir) |=>
      (stage_q[LAST] == $past(din)) && (stage_q[0] == $past(stage_q[1])));

  // R7: clearing empties every stage
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (stage_q == '0));

endmodule

// File: rtl/com_level_map.sv
module com_level_map
  import com_scan_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 120
) (
  input  logic [NUM_STAGES-1:0]   sel,
  input  logic                    frame,
  input  logic                    enable,
  output logic [2*NUM_STAGES-1:0] lvl
);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_line
    drive_lvl_e code;
    assign code           = lvl_of(sel[i], frame, enable);
    assign lvl[2*i +: 2]  = code;
  end

endmodule

// File: rtl/com_scan_shifter.sv
module com_scan_shifter #(
  parameter int unsigned NUM_STAGES = 120
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lp,
  input  logic                    dir,
  input  logic                    disp_off_n,
  input  logic                    frame,
  input  logic                    din,
  output logic                    dout,
  output logic [2*NUM_STAGES-1:0] com_lvl
);

  logic                  lp_fall;
  logic                  shift_evt;
  logic                  clear_evt;
  logic [NUM_STAGES-1:0] stage_q;
  logic [NUM_STAGES-1:0] lvl_lo_bits;

  com_lp_edge i_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .lp   (lp),
    .fall (lp_fall)
  );

  assign clear_evt = ~disp_off_n;
  assign shift_evt = lp_fall & disp_off_n;

  com_scan_chain #(.NUM_STAGES(NUM_STAGES)) i_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (shift_evt),
    .clear  (clear_evt),
    .dir    (dir),
    .din    (din),
    .stage_q(stage_q),
    .dout   (dout)
  );

  com_level_map #(.NUM_STAGES(NUM_STAGES)) i_map (
    .sel   (stage_q),
    .frame (frame),
    .enable(disp_off_n),
    .lvl   (com_lvl)
  );

  // Low bit of every line code, brought out for the polarity check
  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_lo
    assign lvl_lo_bits[i] = com_lvl[2*i];
  end

  // R6: display-off forces every line to ground
  p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |-> (com_lvl == '0));

  // R8: frame 0 codes all have low bit 1, frame 1 codes all have low bit 0
  p_polarity_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_off_n |-> (lvl_lo_bits == {NUM_STAGES{~frame}}));

  // R7: the cycle after display-off release shows no selected line
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(disp_off_n) && frame) |-> (com_lvl == {NUM_STAGES{2'b10}}));

endmodule

// File: tb/test_com_scan_shifter.sv
`timescale 1ns/1ps
module test_com_scan_shifter;

  localparam int N = 120;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, lp, dir, disp_off_n, frame, din;
  logic dout;
  logic [2*N-1:0] com_lvl;

  int checks = 0;
  int errors = 0;
  bit model [N];

  com_scan_shifter #(.NUM_STAGES(N)) i_com_scan_shifter (
    .clk(clk), .rst_n(rst_n), .lp(lp), .dir(dir), .disp_off_n(disp_off_n),
    .frame(frame), .din(din), .dout(dout), .com_lvl(com_lvl)
  );

  // {dir, din, frame} per line pulse
  localparam logic [2:0] VEC [16] = '{
    3'b110, 3'b100, 3'b101, 3'b111, 3'b100, 3'b110, 3'b111, 3'b100,
    3'b010, 3'b000, 3'b011, 3'b001, 3'b010, 3'b010, 3'b001, 3'b000
  };

  function automatic logic [1:0] exp_code(bit s, bit f, bit on);
    if (!on) return 2'b00;
    case ({f, s})
      2'b00:   return 2'b11;
      2'b01:   return 2'b01;
      2'b10:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic model_shift();
    if (dir) begin
      for (int i = N-1; i > 0; i--) model[i] = model[i-1];
      model[0] = din;
    end else begin
      for (int i = 0; i < N-1; i++) model[i] = model[i+1];
      model[N-1] = din;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) model[i] = 1'b0;
  endtask

  task automatic compare(string tag);
    logic [2*N-1:0] e;
    logic ed;
    for (int i = 0; i < N; i++) e[2*i +: 2] = exp_code(model[i], frame, disp_off_n);
    ed = dir ? model[N-1] : model[0];
    checks++;
    if (com_lvl !== e) begin
      errors++;
      $display("FAIL %s levels actual=%h expected=%h", tag, com_lvl, e);
    end
    checks++;
    if (dout !== ed) begin
      errors++;
      $display("FAIL %s dout actual=%b expected=%b", tag, dout, ed);
    end
  endtask

  // One line pulse: high for two cycles, then low, then settle
  task automatic pulse();
    @(negedge clk) lp = 1'b1;
    repeat (2) @(negedge clk);
    lp = 1'b0;
    if (disp_off_n) model_shift();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lp = 1'b0; dir = 1'b1; disp_off_n = 1'b1; frame = 1'b0; din = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1 after release");

    // Table walk: R3 upward and R4 downward moves under both polarities (R8)
    for (int v = 0; v < 16; v++) begin
      dir = VEC[v][2]; din = VEC[v][1]; frame = VEC[v][0];
      pulse();
      compare(dir ? "R3 R8 vector" : "R4 R8 vector");
    end

    // R2: a rising edge alone and a long low level do not move the chain
    dir = 1'b1; din = 1'b1; frame = 1'b0;
    @(negedge clk) lp = 1'b1;
    repeat (4) @(negedge clk);
    compare("R2 rising edge only");
    lp = 1'b0;
    model_shift();
    repeat (8) @(negedge clk);
    compare("R2 single move per fall");

    // Clear the chain through display-off before the end-to-end walks
    disp_off_n = 1'b0;
    repeat (2) @(negedge clk);
    disp_off_n = 1'b1;
    model_clear();
    @(negedge clk);

    // R5/R3: one bit across the full chain upward
    dir = 1'b1; din = 1'b1;
    pulse();
    din = 1'b0;
    for (int k = 1; k < N; k++) pulse();
    compare("R5 R3 bit at stage 119");
    checks++;
    if (dout !== 1'b1) begin errors++; $display("FAIL R5 up dout actual=%b expected=1", dout); end
    pulse();
    compare("R5 bit shifted out upward");

    // R5/R4: one bit across the full chain downward
    dir = 1'b0; din = 1'b1;
    pulse();
    din = 1'b0;
    for (int k = 1; k < N; k++) pulse();
    compare("R5 R4 bit at stage 0");
    checks++;
    if (dout !== 1'b1) begin errors++; $display("FAIL R5 down dout actual=%b expected=1", dout); end

    // R6/R7: blanking in the middle of a scan
    dir = 1'b1; din = 1'b1; pulse(); din = 1'b0; pulse(); din = 1'b1; pulse();
    compare("R3 before blanking");
    @(negedge clk) disp_off_n = 1'b0;
    @(negedge clk);
    compare("R6 blanked frame 0");
    frame = 1'b1;
    @(negedge clk);
    compare("R6 blanked frame 1");
    din = 1'b1;
    pulse();  // ignored while off
    compare("R7 fall ignored while off");
    disp_off_n = 1'b1;
    model_clear();
    @(negedge clk);
    compare("R7 non-select after release");
    repeat (3) @(negedge clk);
    compare("R7 holds until next fall");
    pulse();
    compare("R7 first fall after release");

    // R8: frame toggle alone changes polarity, chain untouched
    din = 1'b0; pulse(); din = 1'b1; pulse();
    frame = 1'b0;
    @(negedge clk);
    compare("R8 toggle to frame 0");
    frame = 1'b1;
    @(negedge clk);
    compare("R8 toggle to frame 1");

    // R1: reset in mid-run with frame 1
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    compare("R1 mid-run reset frame 1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare("R1 after mid-run release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule